// File: doc/BRIEF.md
# Character-Clocked Video Address Generator

This block is the timing core of a character-based CRT controller. One clock is one character time. A horizontal character counter runs across each row and a vertical row counter runs down the frame. Both are bounded by programmable totals. Programmable displayed counts split each direction into an active area and a retrace (border) area. The block drives four outputs:

- a memory address bus, which the system uses both to fetch video data and as the row source for DRAM refresh;
- a display-enable flag;
- a horizontal retrace flag;
- a vertical retrace flag.

Within a frame the address walks forward by one per character, through horizontal retrace as well as the active area. Once the row counter enters vertical retrace, the address freezes at the value it reached at the end of the last displayed row. It stays there until the next frame reloads it from a programmable start address.

A consequence follows directly. With a vertical displayed count of zero, the address never moves during the frame. Refresh sweeping stops for the whole frame. A horizontal displayed count of zero does not stop the sweep; the address still covers one value per character.

Software programs the block through an index-then-data write port. There is no data stream at this block's edge, so every pin is plain control or status, with no valid/ready handshake and no back-pressure.

Top module: `crtc_addr_gen`

## Requirements
- R1: The horizontal counter advances by one per clock. In the clock after it is greater than or equal to the horizontal total register, it returns to 0, so a row lasts horizontal total + 1 characters.
- R2: The row counter advances by one on each horizontal wrap. When a horizontal wrap occurs while the row counter is greater than or equal to the vertical total register, both counters return to 0. That event is the frame wrap.
- R3: `hretrace` is 1 exactly while the horizontal counter is at or above the horizontal displayed register. `vretrace` is 1 exactly while the row counter is at or above the vertical displayed register.
- R4: `disp_en` is 1 exactly when both `hretrace` and `vretrace` are 0.
- R5: In the clock after a frame wrap, `ma` equals the start address. The start address is {start-high register bits [ADDR_W-9:0], start-low register}.
- R6: While `vretrace` is 0, `ma` increases by one (modulo 2^ADDR_W) on every clock, including clocks inside horizontal retrace. A row with horizontal total T therefore spans T+1 addresses.
- R7: While `vretrace` is 1, `ma` holds. Its value is start + vertical displayed × (horizontal total + 1), modulo 2^ADDR_W.
- R8: With the vertical displayed register at 0, `ma` stays at the start address for every clock of the frame, and `vretrace` stays 1.
- R9: A write with `wr_en`=1 and `wr_index`=1 loads the index from `wr_data[4:0]`. A write with `wr_en`=1 and `wr_index`=0 stores `wr_data` into the register the index selects: 0 horizontal total, 1 horizontal displayed, 4 vertical total, 6 vertical displayed, 12 start-high, 13 start-low. A data write to any other index changes nothing.
- R10: A register value written at one clock edge is used by the counter comparisons from the next clock on. This includes the case where a total is lowered below the current count, which causes a wrap on the next clock.
- R11: Reset (`rst_n`=0, asynchronous) clears both counters and `ma` to 0, clears the index to 0, and loads horizontal total 7, horizontal displayed 4, vertical total 5, vertical displayed 3, start address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register port write strobe |
| wr_index | input | 1 | 1: write selects the index; 0: write goes to the selected register |
| wr_data | input | 8 | Index or register value |
| ma | output | ADDR_W | Memory / refresh address |
| disp_en | output | 1 | Active display area flag |
| hretrace | output | 1 | Horizontal retrace flag |
| vretrace | output | 1 | Vertical retrace flag |

## Verification
The address is exercised under four settings, each aimed at one question:

- **Reset defaults.** A normal frame shows the per-character advance, the freeze at start + 3×8, and the reload at the frame wrap.
- **Vertical displayed at zero.** Must leave the address pinned for a full frame. This separates a design that freezes in vertical retrace from one that free-runs.
- **Horizontal displayed at zero with rows displayed.** Must still sweep ten addresses per row. This shows that horizontal retrace alone does not stop the sweep.
- **Write to an unused index, and a horizontal total lowered below the live count.** The first shows the ignored index leaves the frame shape unchanged. The second shows that new totals act from the next comparison.

A cycle-level expectation built from the requirements is compared against every output on every clock throughout all of these tests.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W = 8;
  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IDX_HTOTAL   = 5'd0;
  localparam logic [IDX_W-1:0] IDX_HDISP    = 5'd1;
  localparam logic [IDX_W-1:0] IDX_VTOTAL   = 5'd4;
  localparam logic [IDX_W-1:0] IDX_VDISP    = 5'd6;
  localparam logic [IDX_W-1:0] IDX_START_HI = 5'd12;
  localparam logic [IDX_W-1:0] IDX_START_LO = 5'd13;

  localparam logic [REG_W-1:0] RST_HTOTAL = 8'd7;
  localparam logic [REG_W-1:0] RST_HDISP  = 8'd4;
  localparam logic [REG_W-1:0] RST_VTOTAL = 8'd5;
  localparam logic [REG_W-1:0] RST_VDISP  = 8'd3;

  typedef struct packed {
    logic [REG_W-1:0] htotal;
    logic [REG_W-1:0] hdisp;
    logic [REG_W-1:0] vtotal;
    logic [REG_W-1:0] vdisp;
  } crtc_timing_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_index,
  input  logic [REG_W-1:0]    wr_data,
  output crtc_timing_t        cfg,
  output logic [ADDR_W-1:0]   start_addr
);
  localparam int HI_W = ADDR_W - REG_W;

  logic [IDX_W-1:0] idx;
  logic [HI_W-1:0]  start_hi;
  logic [REG_W-1:0] start_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      cfg.htotal <= RST_HTOTAL;
      cfg.hdisp  <= RST_HDISP;
      cfg.vtotal <= RST_VTOTAL;
      cfg.vdisp  <= RST_VDISP;
      start_hi   <= '0;
      start_lo   <= '0;
    end else if (wr_en) begin
      if (wr_index) begin
        idx <= wr_data[IDX_W-1:0];
      end else begin
        case (idx)
          IDX_HTOTAL:   cfg.htotal <= wr_data;
          IDX_HDISP:    cfg.hdisp  <= wr_data;
          IDX_VTOTAL:   cfg.vtotal <= wr_data;
          IDX_VDISP:    cfg.vdisp  <= wr_data;
          IDX_START_HI: start_hi   <= wr_data[HI_W-1:0];
          IDX_START_LO: start_lo   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign start_addr = {start_hi, start_lo};

  // R9: index write lands in the index register
  a_r9_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_index) |=> (idx == $past(wr_data[IDX_W-1:0])));

  // R9: low start byte follows a data write at its index
  a_r9_start_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_index && idx == IDX_START_LO) |=> (start_addr[REG_W-1:0] == $past(wr_data)));
endmodule

// File: rtl/crtc_counters.sv
module crtc_counters
  import crtc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  crtc_timing_t cfg,
  output logic         h_wrap,
  output logic         f_wrap,
  output logic         hretrace,
  output logic         vretrace,
  output logic         disp_en
);
  logic [REG_W-1:0] hc;
  logic [REG_W-1:0] vc;

  always_comb begin
    h_wrap   = (hc >= cfg.htotal);
    f_wrap   = h_wrap && (vc >= cfg.vtotal);
    hretrace = (hc >= cfg.hdisp);
    vretrace = (vc >= cfg.vdisp);
    disp_en  = !hretrace && !vretrace;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else begin
      hc <= h_wrap ? '0 : hc + 1'b1;
      if (f_wrap)      vc <= '0;
      else if (h_wrap) vc <= vc + 1'b1;
    end
  end

  // R1: wrap returns the character counter to zero
  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (hc == '0));

  // R1: otherwise the character counter steps by one
  a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> (hc == REG_W'($past(hc) + 1'b1)));

  // R2: row counter steps on a horizontal wrap that is not a frame wrap
  a_r2_v_step: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && !f_wrap) |=> (vc == REG_W'($past(vc) + 1'b1)));

  // R2: frame wrap clears the row counter
  a_r2_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
    f_wrap |=> (vc == '0));
endmodule

// File: rtl/crtc_addr_unit.sv
module crtc_addr_unit #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_wrap,
  input  logic              vretrace,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] ma
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ma <= '0;
    else if (f_wrap)    ma <= start_addr;
    else if (!vretrace) ma <= ma + 1'b1;
  end

  // R5: frame wrap reloads the start address
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    f_wrap |=> (ma == $past(start_addr)));

  // R6: sweep one address per character outside vertical retrace
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!vretrace && !f_wrap) |=> (ma == ADDR_W'($past(ma) + 1'b1)));

  // R7: address frozen during vertical retrace
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vretrace && !f_wrap) |=> $stable(ma));
endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_index,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] ma,
  output logic              disp_en,
  output logic              hretrace,
  output logic              vretrace
);
  crtc_timing_t      cfg;
  logic [ADDR_W-1:0] start_addr;
  logic              h_wrap;
  logic              f_wrap;

  crtc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_index(wr_index),
    .wr_data(wr_data), .cfg(cfg), .start_addr(start_addr)
  );

  crtc_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .h_wrap(h_wrap), .f_wrap(f_wrap),
    .hretrace(hretrace), .vretrace(vretrace), .disp_en(disp_en)
  );

  crtc_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .f_wrap(f_wrap), .vretrace(vretrace),
    .start_addr(start_addr), .ma(ma)
  );

  // R4: the active flag never overlaps either retrace flag at the ports
  a_r4_disp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (!hretrace && !vretrace));
endmodule

// File: tb/crtc_addr_gen_bench.sv
module crtc_addr_gen_bench;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_index = 1'b0;
  logic [7:0]    wr_data = 8'd0;
  logic [AW-1:0] ma;
  logic          disp_en, hretrace, vretrace;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  crtc_addr_gen #(.ADDR_W(AW)) u_crtc_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_index(wr_index),
    .wr_data(wr_data), .ma(ma), .disp_en(disp_en),
    .hretrace(hretrace), .vretrace(vretrace)
  );

  // Expectation built from the requirements
  logic [7:0]    s_ht, s_hd, s_vt, s_vd, s_shi, s_slo;
  logic [4:0]    s_idx;
  logic [7:0]    m_hc, m_vc;
  logic [AW-1:0] m_ma;
  logic          m_hw, m_fw;

  always_comb begin
    m_hw = (m_hc >= s_ht);
    m_fw = m_hw && (m_vc >= s_vt);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ht <= 8'd7; s_hd <= 8'd4; s_vt <= 8'd5; s_vd <= 8'd3;
      s_shi <= 8'd0; s_slo <= 8'd0; s_idx <= 5'd0;
      m_hc <= 8'd0; m_vc <= 8'd0; m_ma <= '0;
    end else begin
      if (wr_en && wr_index) s_idx <= wr_data[4:0];
      if (wr_en && !wr_index) begin
        case (s_idx)
          5'd0:  s_ht  <= wr_data;
          5'd1:  s_hd  <= wr_data;
          5'd4:  s_vt  <= wr_data;
          5'd6:  s_vd  <= wr_data;
          5'd12: s_shi <= wr_data;
          5'd13: s_slo <= wr_data;
          default: ;
        endcase
      end
      m_hc <= m_hw ? 8'd0 : m_hc + 8'd1;
      if (m_fw)      m_vc <= 8'd0;
      else if (m_hw) m_vc <= m_vc + 8'd1;
      if (m_fw)               m_ma <= {s_shi[AW-9:0], s_slo};
      else if (m_vc < s_vd)   m_ma <= m_ma + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison of every output (R3, R4, R6/R7)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(ma == m_ma, "R6/R7 ma", int'(ma), int'(m_ma));
      chk(hretrace == (m_hc >= s_hd), "R3 hretrace", int'(hretrace), int'(m_hc >= s_hd));
      chk(vretrace == (m_vc >= s_vd), "R3 vretrace", int'(vretrace), int'(m_vc >= s_vd));
      chk(disp_en == ((m_hc < s_hd) && (m_vc < s_vd)), "R4 disp_en",
          int'(disp_en), int'((m_hc < s_hd) && (m_vc < s_vd)));
    end
  end

  task automatic wr_reg(input logic [4:0] idx, input logic [7:0] val);
    @(negedge clk); wr_en = 1'b1; wr_index = 1'b1; wr_data = {3'b000, idx};
    @(negedge clk); wr_index = 1'b0; wr_data = val;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!(m_hc == 8'd0 && m_vc == 8'd0));
  endtask

  // R11: reset values
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ma == '0, "R11 ma after reset", int'(ma), 0);
    chk(disp_en == 1'b1, "R11 disp_en after reset", int'(disp_en), 1);
    chk(hretrace == 1'b0 && vretrace == 1'b0, "R11 retrace after reset",
        int'({hretrace, vretrace}), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  // R5, R7: default frame, freeze at 3*8 = 24, reload to 0
  task automatic t_default_frame();
    wait_frame();
    chk(ma == 14'd0, "R5 start of frame", int'(ma), 0);
    repeat (23) @(negedge clk);
    chk(vretrace == 1'b0, "R3 last displayed char", int'(vretrace), 0);
    @(negedge clk);
    chk(vretrace == 1'b1, "R3 vretrace begins row 3", int'(vretrace), 1);
    chk(ma == 14'd24, "R7 frozen value", int'(ma), 24);
    repeat (23) @(negedge clk);
    chk(ma == 14'd24, "R7 still frozen at end of frame", int'(ma), 24);
    @(negedge clk);
    chk(ma == 14'd0, "R5 reload after frame wrap", int'(ma), 0);
  endtask

  // R8: vertical displayed zero pins the address for a full frame
  task automatic t_vdisp_zero();
    bit steady = 1'b1;
    wr_reg(5'd0, 8'd5);
    wr_reg(5'd4, 8'd3);
    wr_reg(5'd6, 8'd0);
    wr_reg(5'd12, 8'h01);
    wr_reg(5'd13, 8'h23);
    wait_frame();
    for (int i = 0; i < 24; i++) begin
      if (ma != 14'h123 || vretrace != 1'b1) steady = 1'b0;
      if (i != 23) @(negedge clk);
    end
    chk(steady, "R8 ma pinned whole frame", int'(ma), 'h123);
    wait_frame();
    chk(ma == 14'h123, "R8 pinned after next wrap", int'(ma), 'h123);
  endtask

  // R6: horizontal displayed zero still sweeps 10 addresses per row
  task automatic t_hdisp_zero();
    wr_reg(5'd0, 8'd9);
    wr_reg(5'd1, 8'd0);
    wr_reg(5'd4, 8'd4);
    wr_reg(5'd6, 8'd2);
    wr_reg(5'd12, 8'h00);
    wr_reg(5'd13, 8'h40);
    wait_frame();
    chk(ma == 14'h40, "R5 start of frame", int'(ma), 'h40);
    chk(hretrace == 1'b1, "R3 hretrace with zero hdisp", int'(hretrace), 1);
    repeat (10) @(negedge clk);
    chk(ma == 14'h4A, "R6 row 1 start", int'(ma), 'h4A);
    repeat (10) @(negedge clk);
    chk(ma == 14'h54, "R7 frozen after 2 rows", int'(ma), 'h54);
    repeat (29) @(negedge clk);
    chk(ma == 14'h54, "R7 frozen at last char", int'(ma), 'h54);
    @(negedge clk);
    chk(ma == 14'h40, "R5 reload", int'(ma), 'h40);
  endtask

  // R9: data writes to unused indices change nothing
  task automatic t_ignored_index();
    wr_reg(5'd9, 8'd0);
    wr_reg(5'd2, 8'h55);
    wr_reg(5'd31, 8'h01);
    wait_frame();
    repeat (19) @(negedge clk);
    chk(vretrace == 1'b0, "R9 frame shape kept (row 1)", int'(vretrace), 0);
    @(negedge clk);
    chk(vretrace == 1'b1, "R9 frame shape kept (row 2)", int'(vretrace), 1);
    chk(ma == 14'h54, "R9 address sweep kept", int'(ma), 'h54);
  endtask

  // R10, R1: lowering the total below the live count wraps next clock
  task automatic t_shrink();
    bit never = 1'b1;
    wr_reg(5'd1, 8'd4);
    do @(negedge clk); while (m_hc != 8'd6);
    wr_reg(5'd0, 8'd2);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      if (hretrace) never = 1'b0;
      @(negedge clk);
    end
    chk(never, "R10 short rows never reach hdisp", 0, 0);
    chk(!hretrace, "R1 row of 3 chars", int'(hretrace), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_frame();
    t_vdisp_zero();
    t_hdisp_zero();
    t_ignored_index();
    t_shrink();
    repeat (40) @(negedge clk);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule